// File: doc/BRIEF.md
# Configuration Write Guard

This block sits on the write path between a simple register-bus slave and a bank of configuration registers. For every bus write it decides whether the register bank may accept the data. A guard mode register holds a protection enable bit and is itself reachable only through a 24-bit access key. While protection is on, writes aimed at a fixed group of fourteen configuration offsets are refused. Each refused write is logged in a read-only status register that carries a violation flag and the byte offset of the refused target.

The guard owns two addresses of its own, the mode register and the status register, and answers reads to them on a combinational read port. Every other address passes through untouched, and reads are never gated. A keyed write to the mode register sets or clears the enable bit and also wipes the logged violation. This is the only way to clear it.

Top module: `wp_guard`

## Requirements
- R1: After reset the protection enable is 0, the violation flag is 0 and the logged offset is 0, so a status read returns 0 and a mode read returns 0.
- R2: A write to the mode register (offset 0xF0) whose data bits [31:8] equal 0xA5C3E1 loads the enable from data bit 0. The new value is seen from the next cycle on.
- R3: A mode-register write with any other key value changes nothing: not the enable and not the status.
- R4: While protection is enabled, a write to a protected offset drives wr_allow low and wr_deny high in the same cycle. The protected offsets are the fourteen word-aligned byte offsets 0x10, 0x14, up to 0x44.
- R5: A refused write sets the violation flag and stores its byte offset in the source field. Both are visible from the next cycle on.
- R6: When several writes are refused before a clear, the source field holds the offset of the most recent one.
- R7: A keyed mode-register write (R2) clears the violation flag and the source field, whatever enable value it writes.
- R8: While protection is disabled, writes to protected offsets are allowed (wr_allow high, wr_deny low) and leave the status unchanged.
- R9: Writes to unprotected offsets are allowed in every mode. This covers 0x0C, 0x48 and non-aligned offsets such as 0x12. Reads never raise wr_allow or wr_deny. Neither kind of access changes the status.
- R10: The status register (offset 0xF4) is read-only. Writes to it are ignored and are not passed to the bank, and reading it does not clear the flag.
- R11: A read of offset 0xF0 raises rd_hit and returns the enable in bit 0 with all other bits 0. A read of 0xF4 raises rd_hit and returns the flag in bit 0 and the source field in bits [23:8]. Any other access gives rd_hit 0 and rd_data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W (16) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| wr_allow | output | 1 | The register bank may accept this write |
| wr_deny | output | 1 | This write is refused by protection |
| rd_hit | output | 1 | The read targets a guard-owned register |
| rd_data | output | DATA_W (32) | Read data for guard-owned registers |

## Verification
The bench aims at the edges of the protected window (0x0C, 0x10, 0x44, 0x48) and at the non-aligned offset 0x12. A wrong range comparator would refuse a free register or let a protected one through. It sends mode writes with a key that is off by one bit, both to turn protection on and to turn it off. A design that checked only part of the key would change the enable or drop the logged violation. Back-to-back refusals, writes to the status offset and repeated status reads catch a source field that keeps the first offset, a flag cleared by a read, and a status that is writable. A long stretch of mixed random traffic is then compared every cycle against a behavioural model.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

   // Bit position where the logged offset starts inside the status word.
   localparam int unsigned SRC_LSB = 8;
   // Position of the enable bit in the mode word and of the flag in the status word.
   localparam int unsigned FLAG_BIT = 0;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } wpg_acc_e;

   function automatic wpg_acc_e classify(input logic valid, input logic write);
      if (!valid)
         return ACC_NONE;
      else if (write)
         return ACC_WRITE;
      else
         return ACC_READ;
   endfunction

endpackage

// File: rtl/wpg_addr_match.sv
module wpg_addr_match #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned NUM_PROT  = 14,
   parameter int unsigned BASE      = 16'h0010,
   parameter int unsigned STRIDE    = 4,
   parameter bit          USE_RANGE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   localparam int unsigned SPAN     = NUM_PROT * STRIDE;
   localparam int unsigned LAST     = BASE + SPAN - STRIDE;
   localparam int unsigned STRIDE_M = STRIDE - 1;

   generate
      if (NUM_PROT == 0) begin : g_bad_count
         $error("wpg_addr_match: NUM_PROT must be nonzero");
      end
      if ((STRIDE & STRIDE_M) != 0) begin : g_bad_stride
         $error("wpg_addr_match: STRIDE must be a power of two");
      end
      if (LAST >= (64'd1 << ADDR_W)) begin : g_bad_span
         $error("wpg_addr_match: protected window exceeds the address space");
      end

      if (USE_RANGE) begin : g_range
         // One subtractor and one comparator, whatever the count.
         logic [ADDR_W-1:0] off;
         logic              in_win;
         logic              aligned;
         always_comb begin
            off     = addr - ADDR_W'(BASE);
            in_win  = (addr >= ADDR_W'(BASE)) && (addr <= ADDR_W'(LAST));
            aligned = ((off & ADDR_W'(STRIDE_M)) == '0);
            hit     = in_win && aligned;
         end
      end else begin : g_table
         // One equality comparator per protected offset, OR-reduced.
         logic [NUM_PROT-1:0] eq;
         for (genvar i = 0; i < NUM_PROT; i++) begin : g_ent
            localparam int unsigned ENT = BASE + i * STRIDE;
            assign eq[i] = (addr == ADDR_W'(ENT));
         end
         assign hit = |eq;
      end
   endgenerate

endmodule

// File: rtl/wpg_mode_reg.sv
module wpg_mode_reg #(
   parameter int unsigned   DATA_W = 32,
   parameter int unsigned   KEY_W  = 24,
   parameter logic [23:0]   KEY    = 24'hA5C3E1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic              prot_en,
   output logic              key_ok
);

   import wpg_pkg::*;

   localparam int unsigned KEY_LSB = DATA_W - KEY_W;

   generate
      if (KEY_W != 24) begin : g_bad_key
         $error("wpg_mode_reg: KEY_W must be 24");
      end
      if (KEY_LSB <= FLAG_BIT) begin : g_bad_layout
         $error("wpg_mode_reg: key field overlaps the enable bit");
      end
   endgenerate

   logic [KEY_W-1:0] key_field;
   logic             unused_mid;

   assign key_field  = wdata[DATA_W-1:KEY_LSB];
   assign unused_mid = ^wdata[KEY_LSB-1:FLAG_BIT+1];
   assign key_ok     = wr_en && (key_field == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prot_en <= 1'b0;
      else if (key_ok)
         prot_en <= wdata[FLAG_BIT];
   end

   AST_BAD_KEY_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !key_ok) |=> (prot_en == $past(prot_en)));   // R3

   AST_KEY_LOADS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      key_ok |=> (prot_en == $past(wdata[FLAG_BIT])));   // R2

endmodule

// File: rtl/wpg_status_reg.sv
module wpg_status_reg #(
   parameter int unsigned SRC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             viol,
   input  logic [SRC_W-1:0] viol_addr,
   output logic             flag,
   output logic [SRC_W-1:0] src
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         src  <= '0;
      end else if (clr) begin
         flag <= 1'b0;
         src  <= '0;
      end else if (viol) begin
         flag <= 1'b1;
         src  <= viol_addr;
      end
   end

   AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!flag && (src == '0)));   // R7

   AST_VIOL_LOGS: assert property (@(posedge clk) disable iff (!rst_n)
      (viol && !clr) |=> (flag && (src == $past(viol_addr))));   // R5

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);   // R10

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !viol) |=> ($stable(src) && $stable(flag)));   // R9

endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_PROT  = 14,
   parameter int unsigned PROT_BASE = 16'h0010,
   parameter int unsigned STRIDE    = 4,
   parameter int unsigned MODE_OFF  = 16'h00F0,
   parameter int unsigned STAT_OFF  = 16'h00F4,
   parameter logic [23:0] KEY       = 24'hA5C3E1,
   parameter bit          USE_RANGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              wr_allow,
   output logic              wr_deny,
   output logic              rd_hit,
   output logic [DATA_W-1:0] rd_data
);

   import wpg_pkg::*;

   localparam int unsigned KEY_W = 24;
   localparam int unsigned SRC_W = ADDR_W;

   generate
      if (SRC_LSB + SRC_W > DATA_W) begin : g_bad_src
         $error("wp_guard: source field does not fit the data word");
      end
      if (MODE_OFF == STAT_OFF) begin : g_bad_own
         $error("wp_guard: mode and status offsets must differ");
      end
   endgenerate

   wpg_acc_e          acc;
   logic              is_mode;
   logic              is_stat;
   logic              prot_hit;
   logic              prot_en;
   logic              key_ok;
   logic              mode_wr;
   logic              viol;
   logic              st_flag;
   logic [SRC_W-1:0]  st_src;

   assign acc     = classify(bus_valid, bus_write);
   assign is_mode = (bus_addr == ADDR_W'(MODE_OFF));
   assign is_stat = (bus_addr == ADDR_W'(STAT_OFF));
   assign mode_wr = (acc == ACC_WRITE) && is_mode;

   wpg_addr_match #(
      .ADDR_W    (ADDR_W),
      .NUM_PROT  (NUM_PROT),
      .BASE      (PROT_BASE),
      .STRIDE    (STRIDE),
      .USE_RANGE (USE_RANGE)
   ) i_match (
      .addr (bus_addr),
      .hit  (prot_hit)
   );

   wpg_mode_reg #(
      .DATA_W (DATA_W),
      .KEY_W  (KEY_W),
      .KEY    (KEY)
   ) i_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mode_wr),
      .wdata   (bus_wdata),
      .prot_en (prot_en),
      .key_ok  (key_ok)
   );

   assign viol = (acc == ACC_WRITE) && prot_hit && prot_en;

   wpg_status_reg #(
      .SRC_W (SRC_W)
   ) i_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (key_ok),
      .viol      (viol),
      .viol_addr (bus_addr),
      .flag      (st_flag),
      .src       (st_src)
   );

   always_comb begin
      wr_deny  = viol;
      wr_allow = (acc == ACC_WRITE) && !is_mode && !is_stat && !viol;
   end

   always_comb begin
      rd_hit  = 1'b0;
      rd_data = '0;
      if (acc == ACC_READ) begin
         if (is_mode) begin
            rd_hit            = 1'b1;
            rd_data[FLAG_BIT] = prot_en;
         end else if (is_stat) begin
            rd_hit                      = 1'b1;
            rd_data[FLAG_BIT]           = st_flag;
            rd_data[SRC_LSB +: SRC_W]   = st_src;
         end
      end
   end

   AST_DENY_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      wr_deny |-> prot_en);   // R8

   AST_PROTECTED_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_en && prot_hit && bus_valid && bus_write) |-> (!wr_allow && wr_deny));   // R4

   AST_DENY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_deny |=> st_flag);   // R5

   AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write) |-> (!wr_allow && !wr_deny));   // R9

   AST_READ_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && st_flag) |=> st_flag);   // R10

endmodule

// File: tb/test_wp_guard.sv
module test_wp_guard;

   localparam int unsigned AW = 16;
   localparam int unsigned DW = 32;
   localparam logic [23:0] GOOD_KEY = 24'hA5C3E1;
   localparam logic [23:0] BAD_KEY  = 24'hA5C3E0;
   localparam int MODE_A = 'hF0;
   localparam int STAT_A = 'hF4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic          bus_write = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic          wr_allow, wr_deny, rd_hit;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference state
   int m_en = 0;
   int m_flag = 0;
   int m_src = 0;

   always #10 clk = ~clk;

   wp_guard i_wp_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .wr_allow  (wr_allow),
      .wr_deny   (wr_deny),
      .rd_hit    (rd_hit),
      .rd_data   (rd_data)
   );

   function automatic bit is_prot(input int a);
      return (a >= 'h10) && (a <= 'h44) && ((a % 4) == 0);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Drive one access at the falling edge, compare mid-cycle, update model at the rising edge.
   task automatic step(input bit v, input bit w, input int a, input logic [31:0] d,
                       input string req);
      int e_allow, e_deny, e_hit, e_rd;
      bit keyed;
      @(negedge clk);
      bus_valid = v; bus_write = w; bus_addr = AW'(a); bus_wdata = d;
      e_deny  = (v && w && m_en && is_prot(a)) ? 1 : 0;
      e_allow = (v && w && a != MODE_A && a != STAT_A && !e_deny) ? 1 : 0;
      e_hit   = (v && !w && (a == MODE_A || a == STAT_A)) ? 1 : 0;
      e_rd    = 0;
      if (v && !w && a == MODE_A) e_rd = m_en;
      if (v && !w && a == STAT_A) e_rd = (m_src << 8) | m_flag;
      #2;
      chk(wr_allow == e_allow, req, "wr_allow", wr_allow, e_allow);
      chk(wr_deny == e_deny, req, "wr_deny", wr_deny, e_deny);
      chk(rd_hit == e_hit, req, "rd_hit", rd_hit, e_hit);
      chk(rd_data == DW'(e_rd), req, "rd_data", rd_data, e_rd);
      @(posedge clk);
      keyed = v && w && (a == MODE_A) && (d[31:8] == GOOD_KEY);
      if (keyed) begin
         m_en = d[0]; m_flag = 0; m_src = 0;
      end else if (e_deny) begin
         m_flag = 1; m_src = a;
      end
   endtask

   task automatic rd(input int a, input string req);
      step(1'b1, 1'b0, a, 32'h0, req);
   endtask

   task automatic wr(input int a, input logic [31:0] d, input string req);
      step(1'b1, 1'b1, a, d, req);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      rd(MODE_A, "R1");
      rd(STAT_A, "R1");
      // R8: protection off, protected writes pass
      wr('h10, 32'h1234, "R8");
      wr('h44, 32'h5678, "R8");
      rd(STAT_A, "R8");
      // R3: wrong key cannot enable
      wr(MODE_A, {BAD_KEY, 8'h01}, "R3");
      rd(MODE_A, "R3");
      wr('h20, 32'h1, "R3");
      // R2: good key enables
      wr(MODE_A, {GOOD_KEY, 8'h01}, "R2");
      rd(MODE_A, "R2");
      // R4 / R5: refused write logged
      wr('h10, 32'hFFFF, "R4");
      rd(STAT_A, "R5");
      // R6: most recent offset kept
      wr('h44, 32'h0, "R6");
      wr('h28, 32'h0, "R6");
      rd(STAT_A, "R6");
      // R9: window edges, misaligned, reads
      wr('h0C, 32'h0, "R9");
      wr('h48, 32'h0, "R9");
      wr('h12, 32'h0, "R9");
      rd('h10, "R9");
      step(1'b0, 1'b1, 'h10, 32'h0, "R9");
      rd(STAT_A, "R9");
      // R10: status read-only, read does not clear
      wr(STAT_A, 32'h0, "R10");
      rd(STAT_A, "R10");
      rd(STAT_A, "R10");
      // R3: wrong key cannot disable nor clear
      wr(MODE_A, {BAD_KEY, 8'h00}, "R3");
      rd(MODE_A, "R3");
      rd(STAT_A, "R3");
      // R7: keyed write clears, keeping enable on
      wr(MODE_A, {GOOD_KEY, 8'h01}, "R7");
      rd(STAT_A, "R7");
      rd(MODE_A, "R7");
      wr('h3C, 32'h0, "R5");
      wr(MODE_A, {GOOD_KEY, 8'h00}, "R7");
      rd(STAT_A, "R7");
      // R11: other offsets return nothing
      rd('h00, "R11");
      rd(STAT_A, "R11");
      // random mixed traffic against the model
      for (int i = 0; i < 600; i++) begin
         int sel;
         int a;
         logic [31:0] d;
         sel = int'($urandom_range(0, 9));
         case (sel)
            0, 1:    a = MODE_A;
            2:       a = STAT_A;
            3:       a = int'($urandom_range(0, 'h50));
            default: a = 'h10 + 4 * int'($urandom_range(0, 13));
         endcase
         d = $urandom;
         if (a == MODE_A && $urandom_range(0, 1) == 1) d[31:8] = GOOD_KEY;
         step($urandom_range(0, 7) != 0, $urandom_range(0, 2) != 0, a, d, "R11");
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule